// File: doc/BRIEF.md
# Multiplexed Six-Digit Display Scanner

This block drives a time-multiplexed numeric display of six digits. A display latch takes the digit values of an external decade counter, either copying them every clock or freezing them while a hold input is high. A Johnson-coded ring of six states picks one digit at a time. It starts at the most-significant digit and steps towards the least-significant digit, advancing on each scan tick. For the digit selected, the block presents its BCD nibble, its seven segment lines and a one-hot digit strobe.

After every accepted scan tick a blanking window of a set number of clock cycles turns the strobes and segments off. The BCD output already shows the new digit during that window, so it is settled when the strobe comes on. Leading zeros can be suppressed on the segment lines only. A low level on the scan-park input pins the scan to the most-significant digit and darkens every segment, while the BCD output and the strobe still present that digit. The scan tick is an input, so any clock divider or external oscillator can pace the display.

Top module: `mux_display_scanner`

## Requirements
- R1: While `rst` is high at a clock edge, `bcd_out`, `seg_out` and `strobe_out` are all zero after that edge, the display latch clears to zero and the scan returns to the most-significant digit with no blanking pending.
- R2: Every output is registered and reflects the state held before the edge that loads it. Each scan tick sampled with `scan_park_n` high moves the scan one digit from the most-significant digit (strobe bit NUM_DIGITS-1) towards the least-significant digit (strobe bit 0), then wraps to the most-significant digit. Without a tick the scan does not move, and at most one strobe bit is ever high.
- R3: While `scan_park_n` is low, the scan is forced to the most-significant digit and ticks are ignored. From the next edge on, `seg_out` is zero while `strobe_out` selects the most-significant digit and `bcd_out` shows its value. After release the scan stays on that digit until the next tick.
- R4: An accepted tick starts a blanking window of BLANK_CYCLES clock cycles, during which `strobe_out` and `seg_out` are zero. A tick inside the window restarts it.
- R5: `bcd_out` switches to the new digit in the same cycle in which the blanking window starts, and keeps showing the selected digit while blanking is active.
- R6: While `store` is low, the display latch copies `count_value` at every edge. While `store` is high, the latch keeps its value. Digit i of `count_value` occupies bits 4i+3..4i, and digit NUM_DIGITS-1 is the most-significant digit.
- R7: `seg_out` bit 0 is segment a and bit 6 is segment g, and 1 means lit. The codes 0 to 9 map to 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F. The codes 10 to 15 light no segment.
- R8: When `lzb_off` is low, a digit that is zero and has only zero digits above it shows no segments. The least-significant digit is never suppressed, so an all-zero value shows a single 0. The suppression does not change `strobe_out` or `bcd_out`. Driving `lzb_off` high turns the suppression off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | One-cycle pulse that advances the scan |
| scan_park_n | input | 1 | Low holds the scan on the most-significant digit and darkens the segments |
| store | input | 1 | High freezes the display latch |
| lzb_off | input | 1 | High disables leading-zero suppression |
| count_value | input | 4*NUM_DIGITS | Counter digits in BCD, digit 0 in the low nibble |
| bcd_out | output | 4 | BCD value of the selected digit |
| seg_out | output | 7 | Segments a to g in bits 0 to 6, high means lit |
| strobe_out | output | NUM_DIGITS | One-hot digit strobe, bit NUM_DIGITS-1 is the most-significant digit |

## Verification
The hardest situation to reach is the overlap of timing events: a tick arriving while a blanking window is still running, a park request landing in the middle of a window, and the store input changing in the same cycle as a tick. The stimulus reaches these with directed runs at tick gaps of one, two and three cycles, with a park held across several ignored ticks, and with a long stretch of pseudo-random ticks, parks, store toggles and counter values. The bench follows all of this with its own model and compares the outputs every cycle.

// File: rtl/scan_disp_pkg.sv
package scan_disp_pkg;

  localparam int SEG_W = 7;
  localparam int NIB_W = 4;

  // Segment image for one BCD code; bit 0 = a ... bit 6 = g, 1 = lit.
  function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [NIB_W-1:0] code);
    logic [SEG_W-1:0] s;
    case (code)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NUM_DIGITS   = 6,
  parameter int BLANK_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scan_tick,
  input  logic                  scan_park_n,
  output logic [NUM_DIGITS-1:0] pos_oh,     // bit 0 = MSD position
  output logic                  blanking,
  output logic                  parked
);
  localparam int JW = NUM_DIGITS / 2;
  localparam int CW = $clog2(BLANK_CYCLES + 1);

  logic [JW-1:0] jc_q;
  logic [CW-1:0] blank_q;
  logic          park_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      jc_q    <= '0;
      blank_q <= '0;
      park_q  <= 1'b0;
    end else if (!scan_park_n) begin
      jc_q    <= '0;
      blank_q <= '0;
      park_q  <= 1'b1;
    end else begin
      park_q <= 1'b0;
      if (scan_tick) begin
        jc_q    <= {jc_q[JW-2:0], ~jc_q[JW-1]};
        blank_q <= CW'(BLANK_CYCLES);
      end else if (blank_q != '0) begin
        blank_q <= blank_q - 1'b1;
      end
    end
  end

  // Two-bit decode of each Johnson state into a position.
  genvar k;
  generate
    for (k = 0; k < NUM_DIGITS; k++) begin : g_dec
      if (k == 0) begin : g_first
        assign pos_oh[k] = ~jc_q[JW-1] & ~jc_q[0];
      end else if (k < JW) begin : g_rise
        assign pos_oh[k] = jc_q[k-1] & ~jc_q[k];
      end else if (k == JW) begin : g_full
        assign pos_oh[k] = jc_q[JW-1] & jc_q[0];
      end else begin : g_fall
        assign pos_oh[k] = ~jc_q[k-JW-1] & jc_q[k-JW];
      end
    end
  endgenerate

  assign blanking = (blank_q != '0);
  assign parked   = park_q;

  assert_pos_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(pos_oh));

  assert_tick_moves_R2: assert property (@(posedge clk) disable iff (rst)
    (scan_tick && scan_park_n) |=> !$stable(pos_oh));

  assert_no_tick_still_R2: assert property (@(posedge clk) disable iff (rst)
    (!scan_tick && scan_park_n) |=> $stable(pos_oh));

  assert_park_msd_R3: assert property (@(posedge clk) disable iff (rst)
    !scan_park_n |=> (pos_oh[0] && !blanking && parked));

  assert_tick_blanks_R4: assert property (@(posedge clk) disable iff (rst)
    (scan_tick && scan_park_n) |=> blanking);

endmodule

// File: rtl/display_latch.sv
module display_latch #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             store,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (!store) dout <= din;
  end

  assert_store_holds_R6: assert property (@(posedge clk) disable iff (rst)
    store |=> $stable(dout));

  assert_follow_R6: assert property (@(posedge clk) disable iff (rst)
    !store |=> (dout == $past(din)));

endmodule

// File: rtl/digit_encoder.sv
module digit_encoder
  import scan_disp_pkg::*;
#(
  parameter int NUM_DIGITS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [4*NUM_DIGITS-1:0]   digits,
  input  logic [NUM_DIGITS-1:0]     pos_oh,
  input  logic                      blanking,
  input  logic                      parked,
  input  logic                      lzb_off,
  output logic [NIB_W-1:0]          bcd_out,
  output logic [SEG_W-1:0]          seg_out,
  output logic [NUM_DIGITS-1:0]     strobe_out
);
  // Position p (0 = MSD) holds digit NUM_DIGITS-1-p.
  logic [NIB_W-1:0]      pos_val [NUM_DIGITS];
  logic [NUM_DIGITS-2:0] zero_above;
  logic [NUM_DIGITS-1:0] strobe_nxt;
  logic [NIB_W-1:0]      sel_val;
  logic                  lz_hit;
  logic                  dark;

  genvar p;
  generate
    for (p = 0; p < NUM_DIGITS; p++) begin : g_pos
      assign pos_val[p] = digits[4*(NUM_DIGITS-1-p) +: 4];
      assign strobe_nxt[NUM_DIGITS-1-p] = pos_oh[p] & ~blanking;
    end
    for (p = 0; p < NUM_DIGITS-1; p++) begin : g_zero
      if (p == 0) begin : g_top
        assign zero_above[p] = (pos_val[p] == '0);
      end else begin : g_chain
        assign zero_above[p] = zero_above[p-1] & (pos_val[p] == '0);
      end
    end
  endgenerate

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (pos_oh[i]) sel_val = pos_val[i];
    end
  end

  assign lz_hit = ~lzb_off & (|(pos_oh[NUM_DIGITS-2:0] & zero_above));
  assign dark   = blanking | parked | lz_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcd_out    <= '0;
      seg_out    <= '0;
      strobe_out <= '0;
    end else begin
      bcd_out    <= sel_val;
      seg_out    <= dark ? '0 : bcd_to_seg(sel_val);
      strobe_out <= strobe_nxt;
    end
  end

  assert_strobe_onehot0_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe_out));

  assert_blank_dark_R4: assert property (@(posedge clk) disable iff (rst)
    blanking |=> (strobe_out == '0 && seg_out == '0));

  assert_park_dark_R3: assert property (@(posedge clk) disable iff (rst)
    parked |=> (seg_out == '0 && strobe_out[NUM_DIGITS-1]));

  assert_lz_keeps_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !blanking |=> (strobe_out != '0));

  assert_bad_code_dark_R7: assert property (@(posedge clk) disable iff (rst)
    (seg_out != '0) |-> (bcd_out <= 4'd9));

  assert_lsd_shows_R8: assert property (@(posedge clk) disable iff (rst)
    (pos_oh[NUM_DIGITS-1] && !blanking && !parked && sel_val == '0) |=> (seg_out != '0));

endmodule

// File: rtl/mux_display_scanner.sv
module mux_display_scanner
  import scan_disp_pkg::*;
#(
  parameter int NUM_DIGITS   = 6,
  parameter int BLANK_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scan_tick,
  input  logic                    scan_park_n,
  input  logic                    store,
  input  logic                    lzb_off,
  input  logic [4*NUM_DIGITS-1:0] count_value,
  output logic [3:0]              bcd_out,
  output logic [6:0]              seg_out,
  output logic [NUM_DIGITS-1:0]   strobe_out
);
  localparam int DW = 4 * NUM_DIGITS;

  logic [DW-1:0]         latch_q;
  logic [NUM_DIGITS-1:0] pos_oh;
  logic                  blanking;
  logic                  parked;

  display_latch #(.WIDTH(DW)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .store (store),
    .din   (count_value),
    .dout  (latch_q)
  );

  scan_sequencer #(.NUM_DIGITS(NUM_DIGITS), .BLANK_CYCLES(BLANK_CYCLES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .scan_tick   (scan_tick),
    .scan_park_n (scan_park_n),
    .pos_oh      (pos_oh),
    .blanking    (blanking),
    .parked      (parked)
  );

  digit_encoder #(.NUM_DIGITS(NUM_DIGITS)) u_enc (
    .clk        (clk),
    .rst        (rst),
    .digits     (latch_q),
    .pos_oh     (pos_oh),
    .blanking   (blanking),
    .parked     (parked),
    .lzb_off    (lzb_off),
    .bcd_out    (bcd_out),
    .seg_out    (seg_out),
    .strobe_out (strobe_out)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (bcd_out == '0 && seg_out == '0 && strobe_out == '0));

endmodule

// File: tb/mux_display_scanner_test.sv
module mux_display_scanner_test;
  localparam int N  = 6;
  localparam int B  = 3;
  localparam int DW = 4 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scan_tick = 1'b0;
  logic          scan_park_n = 1'b1;
  logic          store = 1'b0;
  logic          lzb_off = 1'b0;
  logic [DW-1:0] count_value = '0;
  logic [3:0]    bcd_out;
  logic [6:0]    seg_out;
  logic [N-1:0]  strobe_out;

  always #2 clk = ~clk;

  mux_display_scanner #(.NUM_DIGITS(N), .BLANK_CYCLES(B)) uut (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .scan_park_n(scan_park_n),
    .store(store), .lzb_off(lzb_off), .count_value(count_value),
    .bcd_out(bcd_out), .seg_out(seg_out), .strobe_out(strobe_out)
  );

  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  string tag = "R1";

  // Behavioural model state.
  int            m_pos = 0;     // 0 = most-significant digit
  int            m_blank = 0;
  bit            m_park = 1'b0;
  logic [DW-1:0] m_latch = '0;
  logic [3:0]    e_bcd = '0;
  logic [6:0]    e_seg = '0;
  logic [N-1:0]  e_str = '0;

  function automatic logic [6:0] seg_of(input logic [3:0] v);
    logic [6:0] r;
    r = '0;
    if (v == 0) r = 7'h3F;
    if (v == 1) r = 7'h06;
    if (v == 2) r = 7'h5B;
    if (v == 3) r = 7'h4F;
    if (v == 4) r = 7'h66;
    if (v == 5) r = 7'h6D;
    if (v == 6) r = 7'h7D;
    if (v == 7) r = 7'h07;
    if (v == 8) r = 7'h7F;
    if (v == 9) r = 7'h6F;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_bcd = '0; e_seg = '0; e_str = '0;
      m_pos = 0; m_blank = 0; m_park = 1'b0; m_latch = '0;
    end else begin
      int  didx;
      bit  lz;
      logic [3:0] dv;
      didx = N - 1 - m_pos;
      dv = m_latch[didx*4 +: 4];
      lz = !lzb_off && (didx != 0);
      for (int k = N - 1; k >= didx; k--) begin
        if (m_latch[k*4 +: 4] != 0) lz = 1'b0;
      end
      e_bcd = dv;
      e_str = (m_blank > 0) ? '0 : (N'(1) << didx);
      e_seg = (m_blank > 0 || m_park || lz) ? 7'h00 : seg_of(dv);
      if (!store) m_latch = count_value;
      if (!scan_park_n) begin
        m_pos = 0; m_blank = 0; m_park = 1'b1;
      end else begin
        m_park = 1'b0;
        if (scan_tick) begin
          m_pos = (m_pos + 1) % N;
          m_blank = B;
        end else if (m_blank > 0) begin
          m_blank = m_blank - 1;
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    chk("bcd_out", int'(bcd_out), int'(e_bcd));
    chk("seg_out", int'(seg_out), int'(e_seg));
    chk("strobe_out", int'(strobe_out), int'(e_str));
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      scan_tick = 1'b1;
      cyc();
      scan_tick = 1'b0;
      for (int j = 1; j < gap; j++) cyc();
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R2 R4 R5: plain scan with gaps longer than the blanking window
    tag = "R2 R4 R5";
    count_value = 24'h123456;
    run_ticks(14, 6);
    // R7: decoder across all codes, including 10 to 15
    tag = "R7";
    count_value = 24'h987654; run_ticks(7, 4);
    count_value = 24'h321098; run_ticks(7, 4);
    count_value = 24'hABCDEF; run_ticks(7, 4);
    count_value = 24'h1FA2C3; run_ticks(7, 4);
    // R8: leading-zero suppression and its disable input
    tag = "R8";
    count_value = 24'h000700; run_ticks(7, 4);
    count_value = 24'h000000; run_ticks(7, 4);
    count_value = 24'h100000; run_ticks(7, 4);
    count_value = 24'h000090; run_ticks(7, 4);
    lzb_off = 1'b1;
    count_value = 24'h000700; run_ticks(7, 4);
    count_value = 24'h000000; run_ticks(7, 4);
    lzb_off = 1'b0;
    // R6: store freezes the latch, release follows again
    tag = "R6";
    count_value = 24'h246802; run_ticks(2, 4);
    store = 1'b1;
    count_value = 24'h135791; run_ticks(7, 4);
    count_value = 24'h999999; run_ticks(7, 4);
    store = 1'b0;
    run_ticks(7, 4);
    // R3: park holds the MSD, ignores ticks, darkens segments
    tag = "R3";
    count_value = 24'h654321;
    run_ticks(3, 4);
    scan_park_n = 1'b0;
    run_ticks(3, 4);
    repeat (3) cyc();
    scan_park_n = 1'b1;
    repeat (4) cyc();
    run_ticks(7, 4);
    scan_tick = 1'b1; cyc();
    scan_park_n = 1'b0; scan_tick = 1'b0; cyc(); cyc();
    scan_park_n = 1'b1; cyc(); cyc();
    // R4: ticks inside the blanking window restart it
    tag = "R2 R4";
    count_value = 24'h102030;
    run_ticks(8, 1);
    run_ticks(8, 2);
    run_ticks(8, 3);
    repeat (4) cyc();
    // Mixed pseudo-random traffic
    tag = "R2 R3 R5 R6 R8";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      scan_tick   = (r < 35);
      scan_park_n = !(r >= 95);
      store       = ($urandom % 4) == 0;
      lzb_off     = ($urandom % 8) == 0;
      if ($urandom % 5 == 0) begin
        logic [DW-1:0] v;
        v = '0;
        for (int d = 0; d < N; d++) begin
          int x;
          x = (($urandom % 3) == 0) ? 0 : ($urandom % 10);
          v[d*4 +: 4] = 4'(x);
        end
        count_value = v;
      end
      cyc();
    end
    scan_tick = 1'b0; scan_park_n = 1'b1; store = 1'b0; lzb_off = 1'b0;
    // R1: reset in mid-scan
    tag = "R1";
    run_ticks(2, 2);
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
    cyc(); cyc();
    finish_run();
  end

endmodule